// File: doc/BRIEF.md
# Variable-Length Field Extract-and-Extend Unit

This unit takes one 32-bit input word and turns a short, variable-length code held in it into a 16-bit signed number. A 4-bit length field in the word says how many bits the code has (0 to 15). The code sits at the most significant end of a 24-bit data window in the low part of the word. It is taken out by shifting the window right until only `length` bits are left.

The extend rule is not sign replication. When the top bit of the code is 1, the code is in the upper half of its range and is used as it is, a positive number. When that top bit is 0, the code is in the lower half and stands for a negative number: the unit adds `1 - 2^length` to it. A code of length L therefore covers the values -(2^L - 1) to -2^(L-1) and 2^(L-1) to 2^L - 1, and never 0. A length of zero gives 0.

The word is sampled when `in_valid` is high. The result and its valid flag come out of registers on the next clock edge. The result keeps its value until the next strobe.

Top module: `vfx_unit`

## Requirements
- R1: The length is taken from input bits [27:24], as an unsigned number. The data window is input bits [23:0].
- R2: The code is the top `length` bits of the window. Window bit 23 is the most significant bit of the code.
- R3: When the code's most significant bit is 1, the result is the code itself, zero-extended and positive.
- R4: When the code's most significant bit is 0, the result is code - 2^length + 1, which is negative.
- R5: A length of 0 gives a result of 0, whatever the window holds.
- R6: For length 1, code 0 gives -1 and code 1 gives +1.
- R7: Input bits [31:28] have no effect on the result.
- R8: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_value` holds the result for that word. Otherwise `out_valid` is low after the edge.
- R9: `out_value` keeps its value in every cycle that has no strobe, even if `in_word` changes.
- R10: While reset is held, `out_valid` and `out_value` are 0. Reset is applied asynchronously and released on a clock edge.
- R11: `out_value` is 16-bit two's complement. At length 15, a window of all ones gives +32767 and a window of all zeros gives -32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released inside the unit on a clock edge |
| in_valid | input | 1 | Strobe: sample `in_word` at this edge |
| in_word | input | 32 | Bits [27:24] length, bits [23:0] data window, bits [31:28] unused |
| out_valid | output | 1 | High for one cycle after each strobe |
| out_value | output | 16 | Result in signed two's complement, held between strobes |

## Verification
The hardest cases to reach are the edges of the code range for each length: the lowest code just below the half-way point, the code exactly at it, and a full-width code at length 15, where the offset reaches -32767. Random windows seldom land on these. For every length from 0 to 15, the bench therefore sets the window so that the top `length` bits hold all zeros, all ones, exactly 100...0 and exactly 011...1, with random bits below them. It also sets random values in the unused upper nibble, so that any bits that leak through show up as wrong results.

// File: rtl/vfx_pkg.sv
package vfx_pkg;
  localparam int unsigned WORD_W  = 32;  // input word width
  localparam int unsigned WIN_W   = 24;  // data window, low end of the word
  localparam int unsigned LEN_W   = 4;   // width of the length field
  localparam int unsigned LEN_LSB = 24;  // length field position
  localparam int unsigned RES_W   = 16;  // signed result width
endpackage

// File: rtl/vfx_rst_sync.sv
module vfx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/vfx_field_pick.sv
// Keeps the top `len` bits of the window, right-aligned.
module vfx_field_pick #(
  parameter int unsigned WIN_W = 24,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned FLD_W = (1 << LEN_W) - 1
) (
  input  logic [WIN_W-1:0] window,
  input  logic [LEN_W-1:0] len,
  output logic [FLD_W-1:0] field
);
  localparam int unsigned SH_W = $clog2(WIN_W + 1);
  localparam logic [SH_W-1:0] WIN_L = SH_W'(WIN_W);

  logic [SH_W-1:0]  shamt;
  logic [WIN_W-1:0] shifted;

  always_comb begin
    shamt   = WIN_L - SH_W'(len);
    shifted = window >> shamt;   // logical shift on a fixed-width vector
    field   = FLD_W'(shifted);
  end
endmodule

// File: rtl/vfx_sign_map.sv
// Lower-half codes become negative by adding (-1 <<< len) + 1.
module vfx_sign_map #(
  parameter int unsigned LEN_W = 4,
  parameter int unsigned FLD_W = (1 << LEN_W) - 1,
  parameter int unsigned RES_W = 16
) (
  input  logic [FLD_W-1:0]        field,
  input  logic [LEN_W-1:0]        len,
  output logic signed [RES_W-1:0] value
);
  logic [FLD_W:0]          hit;      // hit[k]: len == k
  logic                    code_msb;
  logic signed [RES_W-1:0] ext;
  logic signed [RES_W-1:0] offset;
  logic signed [RES_W-1:0] all_ones;

  for (genvar k = 1; k <= FLD_W; k++) begin : g_msb
    assign hit[k] = (len == LEN_W'(k)) & field[k-1];
  end
  assign hit[0] = 1'b0;

  always_comb begin
    code_msb = |hit;
    all_ones = '1;
    offset   = (all_ones <<< len) + RES_W'(1);  // arithmetic shift, typed vector
    ext      = $signed(RES_W'(field));
    if (len == '0)    value = '0;
    else if (code_msb) value = ext;
    else               value = ext + offset;
  end
endmodule

// File: rtl/vfx_unit.sv
module vfx_unit
  import vfx_pkg::*;
#(
  parameter int unsigned P_WORD_W  = WORD_W,
  parameter int unsigned P_WIN_W   = WIN_W,
  parameter int unsigned P_LEN_W   = LEN_W,
  parameter int unsigned P_LEN_LSB = LEN_LSB,
  parameter int unsigned P_RES_W   = RES_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [P_WORD_W-1:0] in_word,
  output logic                out_valid,
  output logic [P_RES_W-1:0]  out_value
);
  localparam int unsigned FLD_W = (1 << P_LEN_W) - 1;

  logic                      rst_core_n;
  logic [P_LEN_W-1:0]        len;
  logic [P_WIN_W-1:0]        window;
  logic [FLD_W-1:0]          field;
  logic signed [P_RES_W-1:0] mapped;
  logic                      vld_d, vld_q;
  logic [P_RES_W-1:0]        val_d, val_q;

  vfx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  assign len    = in_word[P_LEN_LSB +: P_LEN_W];
  assign window = in_word[P_WIN_W-1:0];

  vfx_field_pick #(.WIN_W(P_WIN_W), .LEN_W(P_LEN_W), .FLD_W(FLD_W)) u_pick (
    .window(window), .len(len), .field(field)
  );

  vfx_sign_map #(.LEN_W(P_LEN_W), .FLD_W(FLD_W), .RES_W(P_RES_W)) u_map (
    .field(field), .len(len), .value(mapped)
  );

  // next state
  always_comb begin
    vld_d = in_valid;
    val_d = val_q;
    if (in_valid) val_d = mapped;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) val_q <= val_d;
    end
  end

  assign out_valid = vld_q;
  assign out_value = val_q;

  // R8: a strobe produces exactly one valid cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> !out_valid);
  // R9: no strobe, no change
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> $stable(out_value));
  // R5: zero length gives zero
  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_word[P_LEN_LSB +: P_LEN_W] == '0) |=> (out_value == '0));
  // R3/R4: sign of result is the inverse of window bit 23 when length > 0
  a_r4_sign: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_word[P_LEN_LSB +: P_LEN_W] != '0)
      |=> (out_value[P_RES_W-1] == !$past(in_word[P_WIN_W-1])));
  // R3: nonzero length never yields zero
  a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_word[P_LEN_LSB +: P_LEN_W] != '0) |=> (out_value != '0));
endmodule

// File: tb/tb_vfx_unit.sv
module tb_vfx_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [15:0] out_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  vfx_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_value(out_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_val(logic [31:0] w);
    int n, win, raw;
    n   = int'(w[27:24]);
    win = int'(w[23:0]);
    if (n == 0) return 0;
    raw = win / (1 << (24 - n));
    if (raw < (1 << (n - 1))) return raw - (1 << n) + 1;
    return raw;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one strobe, sample after the capturing edge
  task automatic apply(input logic [31:0] w, input string tag);
    int got, exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    got = int'($signed(out_value));
    exp = ref_val(w);
    check(out_valid == 1'b1, {tag, " R8 valid"}, int'(out_valid), 1);
    check(got == exp, tag, got, exp);
  endtask

  task automatic t_reset();   // R10
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
    check(out_value == '0, "R10 value in reset", int'(out_value), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid after release", int'(out_valid), 0);
  endtask

  task automatic t_size_sweep();  // R1 R2 R3 R4 R5
    for (int n = 0; n < 16; n++) begin
      for (int p = 0; p < 8; p++) begin
        logic [23:0] win;
        logic [23:0] lowmask;
        win = 24'($urandom);
        lowmask = (n == 0) ? 24'hFFFFFF : ((24'h1 << (24 - n)) - 24'h1);
        case (p)
          0: win = win & lowmask;                     // code all zeros
          1: win = win | ~lowmask;                    // code all ones
          2: if (n > 0) win = (win & lowmask) | (24'h800000);                    // 100..0
          3: if (n > 0) win = (win & lowmask) | (~lowmask & 24'h7FFFFF);         // 011..1
          default: ;
        endcase
        apply({4'($urandom), 4'(n), win}, $sformatf("R2 R3 R4 len=%0d p=%0d", n, p));
      end
    end
  endtask

  task automatic t_zero_len();  // R5
    apply({4'h0, 4'd0, 24'hFFFFFF}, "R5 len0 ones");
    apply({4'hF, 4'd0, 24'hA5A5A5}, "R5 len0 pattern");
    check(out_value == '0, "R5 len0 value", int'(out_value), 0);
  endtask

  task automatic t_len_one();  // R6
    apply({4'h0, 4'd1, 24'h7FFFFF}, "R6 len1 code0");
    check(int'($signed(out_value)) == -1, "R6 code0 -> -1", int'($signed(out_value)), -1);
    apply({4'h0, 4'd1, 24'h800000}, "R6 len1 code1");
    check(int'($signed(out_value)) == 1, "R6 code1 -> +1", int'($signed(out_value)), 1);
  endtask

  task automatic t_upper_ignored();  // R7
    int first;
    apply({4'h0, 4'd9, 24'h3C0F11}, "R7 upper 0");
    first = int'($signed(out_value));
    apply({4'hF, 4'd9, 24'h3C0F11}, "R7 upper F");
    check(int'($signed(out_value)) == first, "R7 upper bits ignored",
          int'($signed(out_value)), first);
  endtask

  task automatic t_hold();  // R9 R8
    logic [15:0] held;
    apply({4'h0, 4'd12, 24'h123456}, "R9 setup");
    held = out_value;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_word = $urandom;
      check(out_value == held, "R9 hold without strobe", int'(out_value), int'(held));
      check(out_valid == 1'b0, "R8 no valid without strobe", int'(out_valid), 0);
    end
  endtask

  task automatic t_extremes();  // R11
    apply({4'h0, 4'd15, 24'hFFFFFF}, "R11 len15 ones");
    check(int'($signed(out_value)) == 32767, "R11 max", int'($signed(out_value)), 32767);
    apply({4'h0, 4'd15, 24'h000000}, "R11 len15 zeros");
    check(int'($signed(out_value)) == -32767, "R11 min", int'($signed(out_value)), -32767);
  endtask

  task automatic t_back_to_back();  // R8
    @(negedge clk);
    in_valid = 1'b1; in_word = {4'h0, 4'd4, 24'hF00000};
    @(negedge clk);
    check(int'($signed(out_value)) == 15, "R8 b2b first", int'($signed(out_value)), 15);
    in_word = {4'h0, 4'd4, 24'h000000};
    @(negedge clk);
    in_valid = 1'b0;
    check(int'($signed(out_value)) == -15, "R8 b2b second", int'($signed(out_value)), -15);
    check(out_valid == 1'b1, "R8 b2b valid", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid drops", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_zero_len();
    t_len_one();
    t_size_sweep();
    t_upper_ignored();
    t_hold();
    t_extremes();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule